// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns a signed product of `2*WIDTH` bits. It works through the multiplier one bit per clock. At each step it looks at the current low multiplier bit and the bit that was examined in the previous step. It subtracts the multiplicand from the upper accumulator when a run of ones begins, adds it back when the run ends, and leaves the accumulator alone otherwise. It then shifts the accumulator pair right arithmetically.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` is high for exactly `WIDTH` cycles. A one-cycle `done` pulse then marks a valid `product`, which holds its value until the next accepted start. A start that arrives while a multiplication is running is ignored.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while idle captures `mcand` and `mplier` on that edge, and `busy` is high in the following cycle.
- R3: If `start` is accepted on clock edge k, `busy` stays high through edge k+WIDTH-1. On edge k+WIDTH, `busy` falls and `done` rises for exactly one cycle. `busy` and `done` are never high together.
- R4: When `done` is high, `product` equals the signed product of the captured operands, read as two's complement values. This holds for every operand pair, including the most negative value on either or both inputs.
- R5: A `start` pulse while `busy` is high has no effect. The running product and its timing stay those of the operands captured at the accepted start.
- R6: After `done`, `product` holds its value, whatever the inputs do, until the next accepted start.
- R7: At each step the bit pair (current low multiplier bit, previous bit) selects the accumulator operation: 1,0 subtracts the multiplicand; 0,1 adds it; 0,0 and 1,1 leave it unchanged. After that operation the pair is shifted right arithmetically by one bit.
- R8: Every accepted start clears the upper accumulator and the saved previous bit, so results of back-to-back multiplications do not depend on earlier runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin; honoured only while idle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product, upper half then lower half |

## Verification
The embedded assertions check the handshake on every cycle. They confirm that `done` is a single-cycle pulse that never overlaps `busy` and that `busy` only rises after a start. They also confirm that each load clears the accumulator and the saved bit, that the accumulator is frozen between runs, and that a step whose bit pair calls for no operation reduces to a pure arithmetic shift. The arithmetic result itself, the exact cycle of `done`, and the ignoring of a start while busy can only be shown by the bench's scenarios. These are an exhaustive sweep of all operand pairs at four bits, and directed corners plus random pairs at eight bits, each compared against a signed multiply computed in the bench.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator and saved bit
    logic step;   // perform one recode/add/shift iteration
  } booth_strobe_t;

  // Accumulator operation chosen by the bit-pair recoder
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10
  } booth_op_e;

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output booth_strobe_t strb,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_e;

  ctrl_state_e stateReg;
  logic [CW-1:0] stepCnt;
  logic doneReg;

  always_comb begin
    strb.load = (stateReg == ST_IDLE) && start;
    strb.step = (stateReg == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateReg <= ST_IDLE;
      stepCnt  <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (stateReg)
        ST_IDLE: begin
          if (start) begin
            stateReg <= ST_RUN;
            stepCnt  <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST) begin
            stateReg <= ST_IDLE;
            doneReg  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: stateReg <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateReg == ST_RUN);
  assign done = doneReg;

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      yCur,
  input  logic      yPrev,
  output booth_op_e op
);

  always_comb begin
    unique case ({yCur, yPrev})
      2'b10:   op = OP_SUB;   // run of ones begins
      2'b01:   op = OP_ADD;   // run of ones ends
      default: op = OP_HOLD;  // inside a run, or inside zeros
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] addend,
  input  booth_op_e        op,
  output logic [WIDTH:0]   result
);

  // One guard bit keeps the sign intact when the operand is the most negative value
  logic [WIDTH:0] accExt;
  logic [WIDTH:0] addExt;

  always_comb begin
    accExt = {acc[WIDTH-1], acc};
    addExt = {addend[WIDTH-1], addend};
    unique case (op)
      OP_ADD:  result = accExt + addExt;
      OP_SUB:  result = accExt - addExt;
      default: result = accExt;
    endcase
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  booth_strobe_t      strb,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0] xReg;
  logic [WIDTH-1:0] uReg;
  logic [WIDTH-1:0] vReg;
  logic [WIDTH-1:0] yReg;
  logic             yPrev;
  booth_op_e        stepOp;
  logic [WIDTH:0]   sumWide;

  booth_recode recoder (
    .yCur  (yReg[0]),
    .yPrev (yPrev),
    .op    (stepOp)
  );

  booth_addsub #(.WIDTH(WIDTH)) adder (
    .acc    (uReg),
    .addend (xReg),
    .op     (stepOp),
    .result (sumWide)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xReg  <= '0;
      uReg  <= '0;
      vReg  <= '0;
      yReg  <= '0;
      yPrev <= 1'b0;
    end else if (strb.load) begin
      xReg  <= mcand;
      uReg  <= '0;
      vReg  <= '0;
      yReg  <= mplier;
      yPrev <= 1'b0;
    end else if (strb.step) begin
      // arithmetic right shift of the guarded sum through U into V
      uReg  <= sumWide[WIDTH:1];
      vReg  <= {sumWide[0], vReg[WIDTH-1:1]};
      yReg  <= {yReg[0], yReg[WIDTH-1:1]};
      yPrev <= yReg[0];
    end
  end

  assign product = {uReg, vReg};

  // R8
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (uReg == '0) && !yPrev);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.step) |=> ($stable(uReg) && $stable(vReg)));

  // R7
  pure_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.load && (yReg[0] == yPrev)) |=>
      (uReg == {$past(uReg[WIDTH-1]), $past(uReg[WIDTH-1:1])}));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  booth_strobe_t strb;

  booth_ctrl #(.WIDTH(WIDTH)) sequencer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  booth_datapath #(.WIDTH(WIDTH)) datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;

  localparam int CLK_PERIOD = 10;
  localparam int WN = 4;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic          startN = 1'b0;
  logic [WN-1:0] aN = '0, bN = '0;
  logic          busyN, doneN;
  logic [2*WN-1:0] prodN;

  logic          startW = 1'b0;
  logic [WW-1:0] aW = '0, bW = '0;
  logic          busyW, doneW;
  logic [2*WW-1:0] prodW;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_seq_mult #(.WIDTH(WN)) uut (
    .clk(clk), .rst_n(rst_n), .start(startN), .mcand(aN), .mplier(bN),
    .busy(busyN), .done(doneN), .product(prodN)
  );

  booth_seq_mult #(.WIDTH(WW)) uutWide (
    .clk(clk), .rst_n(rst_n), .start(startW), .mcand(aW), .mplier(bW),
    .busy(busyW), .done(doneW), .product(prodW)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Narrow run; optional start pulse in mid-run with other operands (R5)
  task automatic runNarrow(input logic [WN-1:0] a, input logic [WN-1:0] b, input bit poke);
    logic signed [2*WN-1:0] expP;
    bit timingOk;
    expP = $signed(a) * $signed(b);
    @(negedge clk);
    aN = a; bN = b; startN = 1'b1;
    @(negedge clk);
    startN = 1'b0;
    timingOk = busyN && !doneN;               // R2: busy in the cycle after start
    for (int i = 1; i <= WN; i++) begin
      if (poke && i == 2) begin
        aN = ~a; bN = b + 1'b1; startN = 1'b1;
      end
      @(negedge clk);
      startN = 1'b0;
      if (i < WN) timingOk = timingOk && busyN && !doneN;
      else        timingOk = timingOk && !busyN && doneN;
    end
    check(timingOk, poke ? "R5 timing" : "R3 timing", longint'(doneN), 1);
    check($signed(prodN) == expP, poke ? "R5 product" : "R4/R7 product",
          longint'($signed(prodN)), longint'(expP));
  endtask

  task automatic runWide(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic signed [2*WW-1:0] expP;
    expP = $signed(a) * $signed(b);
    @(negedge clk);
    aW = a; bW = b; startW = 1'b1;
    @(negedge clk);
    startW = 1'b0;
    for (int i = 1; i <= WW; i++) @(negedge clk);
    check(doneW && !busyW, "R3 wide done", longint'(doneW), 1);
    check($signed(prodW) == expP, "R4 wide product",
          longint'($signed(prodW)), longint'(expP));
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        bad++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin : stimulus
    logic [2*WN-1:0] held;
    repeat (3) @(negedge clk);
    // R1
    check(!busyN && !doneN && prodN == '0, "R1 reset narrow", longint'(prodN), 0);
    check(!busyW && !doneW && prodW == '0, "R1 reset wide", longint'(prodW), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R7 R8: exhaustive back-to-back sweep at 4 bits
    for (int a = 0; a < (1 << WN); a++)
      for (int b = 0; b < (1 << WN); b++)
        runNarrow(WN'(a), WN'(b), 1'b0);

    // R5: start while busy is ignored
    runNarrow(4'b1000, 4'b1000, 1'b1);
    runNarrow(4'b0111, 4'b1011, 1'b1);

    // R6: product holds after done while inputs change
    runNarrow(4'b1101, 4'b0110, 1'b0);
    held = prodN;
    aN = 4'b0011; bN = 4'b0101;
    repeat (4) @(negedge clk);
    check(prodN == held && !doneN && !busyN, "R6 hold", longint'(prodN), longint'(held));

    // R4 corners at 8 bits
    runWide(8'h80, 8'h80);
    runWide(8'h80, 8'h7F);
    runWide(8'h7F, 8'h7F);
    runWide(8'hFF, 8'h80);
    runWide(8'h00, 8'hAA);
    runWide(8'h55, 8'hAA);
    for (int k = 0; k < 400; k++) runWide(8'($urandom), 8'($urandom));

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule